// File: doc/BRIEF.md
# SHA-256 Message Schedule Expander

This block turns one already-padded 512-bit chunk into the 64 words that the SHA-256 compression rounds consume. After a start strobe, the sixteen 32-bit chunk words arrive one per accepted cycle. Each is forwarded at once to the output, tagged with its round index. As soon as the sixteenth word is taken, the block produces the remaining forty-eight words on consecutive cycles, so the output stream stays in step with a round engine that consumes one word per clock.

A 16-stage shift register holds the most recent words. Each derived word is the modulo-2^32 sum of four terms: the word sixteen places back, the small sigma-zero of the word fifteen back, the word seven back, and the small sigma-one of the word two back. Two chained 3:2 carry-save stages reduce the four terms to a sum and carry pair. A single carry-propagate adder then produces the result. Padding, the round function and the final hash are handled elsewhere.

Top module: `sha256_sched_expander`

## Requirements
- R1: While synchronous reset `rst` is high, and in the cycle after it is released, `out_valid_o` is 0 and `out_round_o` is 0.
- R2: A cycle with `start_i` high sets the round index to 0 in the following cycle, and the block begins loading a new chunk.
- R3: During loading (round index 0..15), each cycle with `in_valid_i` high drives `out_valid_o`=1 and `out_word_o`=`in_word_i` in that same cycle, with `out_round_o` equal to the load position. The round index then advances by one.
- R4: `in_valid_i` is ignored when no chunk is in progress: `out_valid_o` stays 0 and `out_round_o` does not move.
- R5: For rounds 16..63, `out_word_o` = W[i-16] + s0(W[i-15]) + W[i-7] + s1(W[i-2]) mod 2^32. Here s0(x) = ROTR7(x)^ROTR18(x)^SHR3(x) and s1(x) = ROTR17(x)^ROTR19(x)^SHR10(x).
- R6: The cycle after W15 is accepted, `out_valid_o` is 1 with round 16. Rounds 17..63 follow on consecutive cycles with no gap, and `in_valid_i` has no effect during them.
- R7: After round 63, `out_valid_o` stays 0 until a new start strobe and new input words arrive.
- R8: Carries out of bit 31 are discarded at every stage, so words with all bits set produce the modulo-2^32 result.
- R9: A start strobe in the middle of a chunk abandons it, and the next accepted word is reported as round 0.
- R10: During loading, a cycle with `in_valid_i` low gives `out_valid_o`=0 and leaves the round index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new chunk |
| in_valid_i | input | 1 | `in_word_i` carries a chunk word |
| in_word_i | input | 32 | Chunk word, W0 first |
| out_valid_o | output | 1 | `out_word_o` is a schedule word |
| out_word_o | output | 32 | Schedule word W[out_round_o] |
| out_round_o | output | 6 | Round index of the current word |

## Verification
The bench targets the tap alignment of the window: the "abc" block gives W16=0x61626380 and W17=0x000F0000, so an off-by-one tap or a swapped sigma breaks these words first. An all-ones block stresses carry handling in the compressor chain: a mis-shifted carry vector or a kept bit-32 carry corrupts most of its words. Loading gaps, an aborted chunk and stray input after round 63 each probe the counter. A design that advances on idle cycles, fails to restart, or keeps emitting past W63 shows a wrong round index or a stray valid.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t sum;
    word_t carry;
  } cs_pair_t;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t small_sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  // Bitwise 3:2 compressor; carry vector is pre-shifted to its weight,
  // the bit leaving position 31 is dropped (modulo 2^32).
  function automatic cs_pair_t compress32(input word_t a, input word_t b, input word_t c);
    cs_pair_t r;
    r.sum   = a ^ b ^ c;
    r.carry = ((a & b) | (a & c) | (b & c)) << 1;
    return r;
  endfunction
endpackage

// File: rtl/sched_window.sv
module sched_window #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_en,
  input  logic [W-1:0]            new_word,
  output logic [DEPTH-1:0][W-1:0] taps_o
);
  logic [DEPTH-1:0][W-1:0] stage_q;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[k] <= '0;
        end else if (shift_en) begin
          if (k == 0) stage_q[k] <= new_word;
          else        stage_q[k] <= stage_q[k-1];
        end
      end
    end
  endgenerate

  assign taps_o = stage_q;

  p_window_shift_r5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> stage_q[1] == $past(stage_q[0]) && stage_q[0] == $past(new_word));
endmodule

// File: rtl/sched_csa_tree.sv
module sched_csa_tree
  import sched_pkg::*;
(
  input  word_t op_far,   // W[i-16]
  input  word_t op_s0in,  // W[i-15]
  input  word_t op_mid,   // W[i-7]
  input  word_t op_s1in,  // W[i-2]
  output word_t sum_o,
  output word_t part_sum_o,
  output word_t part_carry_o
);
  cs_pair_t lvl1, lvl2;

  always_comb begin
    lvl1 = compress32(op_far, small_sig0(op_s0in), op_mid);
    lvl2 = compress32(lvl1.sum, lvl1.carry, small_sig1(op_s1in));
  end

  assign part_sum_o   = lvl2.sum;
  assign part_carry_o = lvl2.carry;
  assign sum_o        = lvl2.sum + lvl2.carry;  // the single carry-propagate adder
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl #(
  parameter int ROUNDS = 64,
  parameter int LOADS  = 16,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             in_valid_i,
  output logic [CNT_W-1:0] round_o,
  output logic             load_take_o,
  output logic             expand_o
);
  localparam logic [CNT_W-1:0] LAST_R  = CNT_W'(ROUNDS - 1);
  localparam logic [CNT_W-1:0] FIRST_X = CNT_W'(LOADS);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_load;

  assign in_load     = busy_q && (cnt_q < FIRST_X);
  assign load_take_o = in_load && in_valid_i && !start_i;
  assign expand_o    = busy_q && !in_load && !start_i;
  assign round_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (load_take_o) begin
      cnt_q  <= cnt_q + 1'b1;
    end else if (expand_o) begin
      if (cnt_q == LAST_R) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> round_o == '0);
  p_gap_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (in_load && !in_valid_i && !start_i) |=> round_o == $past(round_o));
  p_no_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (expand_o && round_o != LAST_R) |=> (expand_o || $past(start_i) || start_i));
  p_stop_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    (expand_o && round_o == LAST_R) |=> !busy_q);
  p_mutex_r3: assert property (@(posedge clk) disable iff (rst)
    !(load_take_o && expand_o));
endmodule

// File: rtl/sha256_sched_expander.sv
module sha256_sched_expander
  import sched_pkg::*;
#(
  parameter int ROUNDS = 64,
  parameter int LOADS  = 16,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             in_valid_i,
  input  logic [31:0]      in_word_i,
  output logic             out_valid_o,
  output logic [31:0]      out_word_o,
  output logic [CNT_W-1:0] out_round_o
);
  // Tap positions relative to the word being formed (index 0 = W[i-1]).
  localparam int T_FAR  = LOADS - 1;  // W[i-16]
  localparam int T_S0   = LOADS - 2;  // W[i-15]
  localparam int T_MID  = 6;          // W[i-7]
  localparam int T_S1   = 1;          // W[i-2]

  logic                       load_take, expand;
  logic [CNT_W-1:0]           round;
  logic [LOADS-1:0][WORD_W-1:0] taps;
  word_t                      new_word, next_word, ps, pc;

  sched_ctrl #(.ROUNDS(ROUNDS), .LOADS(LOADS)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .in_valid_i(in_valid_i),
    .round_o(round), .load_take_o(load_take), .expand_o(expand)
  );

  sched_csa_tree u_tree (
    .op_far(taps[T_FAR]), .op_s0in(taps[T_S0]), .op_mid(taps[T_MID]),
    .op_s1in(taps[T_S1]), .sum_o(next_word), .part_sum_o(ps), .part_carry_o(pc)
  );

  assign new_word = load_take ? in_word_i : next_word;

  sched_window #(.DEPTH(LOADS), .W(WORD_W)) u_win (
    .clk(clk), .rst(rst), .shift_en(load_take | expand),
    .new_word(new_word), .taps_o(taps)
  );

  assign out_valid_o = load_take | expand;
  assign out_word_o  = new_word;
  assign out_round_o = round;

  p_sum_mod_r8: assert property (@(posedge clk) disable iff (rst)
    expand |-> ps + pc == taps[T_FAR] + small_sig0(taps[T_S0]) + taps[T_MID] + small_sig1(taps[T_S1]));
  p_pass_through_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && out_round_o < CNT_W'(LOADS)) |-> out_word_o == in_word_i);
  p_round_step_r6: assert property (@(posedge clk) disable iff (rst)
    (expand && out_round_o != CNT_W'(ROUNDS - 1) && !start_i) |=> out_round_o == $past(out_round_o) + 1'b1);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !out_valid_o && out_round_o == '0);
endmodule

// File: tb/tb_sha256_sched_expander.sv
module tb_sha256_sched_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_word_i = '0;
  logic        out_valid_o;
  logic [31:0] out_word_o;
  logic [5:0]  out_round_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] ref_w [64];

  always #2 clk = ~clk;  // 250 MHz

  sha256_sched_expander dut (
    .clk(clk), .rst(rst), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_word_i(in_word_i), .out_valid_o(out_valid_o),
    .out_word_o(out_word_o), .out_round_o(out_round_o)
  );

  // Blocks: padded "abc", all ones, walking-bit pattern.
  localparam logic [31:0] BLK [3][16] = '{
    '{32'h61626380, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h00000018},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
      32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
      32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{32'h00000001, 32'h80000000, 32'h12345678, 32'hDEADBEEF, 32'h0F0F0F0F, 32'hF0F0F0F0,
      32'hA5A5A5A5, 32'h5A5A5A5A, 32'h00010000, 32'hCAFEF00D, 32'h7FFFFFFF, 32'h80000001,
      32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210}
  };

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  task automatic build_ref(input int b);
    for (int i = 0; i < 16; i++) ref_w[i] = BLK[b][i];
    for (int i = 16; i < 64; i++) begin
      logic [31:0] a, c;
      a = rr(ref_w[i-15], 7) ^ rr(ref_w[i-15], 18) ^ {3'b0, ref_w[i-15][31:3]};
      c = rr(ref_w[i-2], 17) ^ rr(ref_w[i-2], 19) ^ {10'b0, ref_w[i-2][31:10]};
      ref_w[i] = 32'(64'(ref_w[i-16]) + 64'(a) + 64'(ref_w[i-7]) + 64'(c));
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1; in_valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Load a block (optionally with a gap after word 5), then check all 64 outputs.
  task automatic run_block(input int b, input bit gap);
    build_ref(b);
    pulse_start();
    #1 chk(out_round_o == 0, "R2 round after start", 64'(out_round_o), 0);
    for (int i = 0; i < 16; i++) begin
      if (gap && i == 5) begin
        in_valid_i = 1'b0; in_word_i = 32'hBADBAD00;
        #1 chk(!out_valid_o && out_round_o == 5, "R10 gap holds", {out_valid_o, out_round_o}, 5);
        @(negedge clk);
      end
      in_valid_i = 1'b1; in_word_i = BLK[b][i];
      #1 chk(out_valid_o && out_round_o == 6'(i) && out_word_o == ref_w[i], "R3 load pass",
             {out_valid_o, out_round_o, out_word_o}, {1'b1, 6'(i), ref_w[i]});
      @(negedge clk);
    end
    in_valid_i = 1'b1; in_word_i = 32'h13579BDF;  // must be ignored (R6)
    for (int i = 16; i < 64; i++) begin
      #1 chk(out_valid_o && out_round_o == 6'(i) && out_word_o == ref_w[i], "R5/R6/R8 expand",
             {out_valid_o, out_round_o, out_word_o}, {1'b1, 6'(i), ref_w[i]});
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    #1 chk(!out_valid_o, "R7 valid drops after 63", 64'(out_valid_o), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(!out_valid_o && out_round_o == 0, "R1 in reset", {out_valid_o, out_round_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    #1 chk(!out_valid_o && out_round_o == 0, "R1 after reset", {out_valid_o, out_round_o}, 0);

    // R4: idle input ignored
    in_valid_i = 1'b1; in_word_i = 32'hFACEFACE;
    for (int k = 0; k < 3; k++) begin
      #1 chk(!out_valid_o && out_round_o == 0, "R4 idle ignore", {out_valid_o, out_round_o}, 0);
      @(negedge clk);
    end
    in_valid_i = 1'b0;

    // table walk
    for (int b = 0; b < 3; b++) run_block(b, b == 2);

    // directed known words for "abc" (R5)
    build_ref(0);
    chk(ref_w[16] == 32'h61626380, "R5 model W16", 64'(ref_w[16]), 64'h61626380);
    chk(ref_w[17] == 32'h000F0000, "R5 model W17", 64'(ref_w[17]), 64'h000F0000);

    // R7: after round 63 stays quiet despite input
    in_valid_i = 1'b1; in_word_i = 32'h11111111;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1 chk(!out_valid_o, "R7 quiet after chunk", 64'(out_valid_o), 0);
    end
    in_valid_i = 1'b0;

    // R9: abort mid-load, restart
    pulse_start();
    for (int i = 0; i < 7; i++) begin
      in_valid_i = 1'b1; in_word_i = 32'hEEEE0000 + 32'(i);
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    #1 chk(out_round_o == 7, "R9 partial load", 64'(out_round_o), 7);
    run_block(0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule